// File: doc/BRIEF.md
# Mixed-decay H-bridge PWM controller

This block generates the four gate drives of one H-bridge winding and regulates its current with a fixed off-time scheme. An on phase drives one diagonal of the bridge, chosen by a polarity input. A current-trip comparator can end the on phase once a blanking window has passed. The off-time that follows has a fixed length. Its first 5/16 (rounded down) uses fast decay, which drives the opposite diagonal. The rest uses slow decay, with both low-side switches on. When the off-time expires, the next on phase starts.

During decay the conducting switches act as synchronous rectifiers. A near-zero-current input releases them, so the load current cannot reverse. Every change between two different non-idle gate patterns passes through a dead interval in which all four gates are off.

The gates are forced off in four cases: the active-low enable is high, an overtemperature or undervoltage flag is set, the active-low sleep input is low, or the wake delay has not yet run out. Enable and the fault flags only mask the gates. Sleep also holds the regulator idle and restarts the wake delay.

Top module: `hbridge_decay_ctrl`

## Requirements
- R1: After reset and while the wake delay runs, all gates are off and status is zero. The ready bit (status bit 0) rises once WAKE_CYC clock edges have passed with sleep_n_i high.
- R2: In the on phase with latched polarity 1, gate_ah_o and gate_bl_o are on. With polarity 0, gate_bh_o and gate_al_o are on.
- R3: The trip input ends the on phase only after BLANK_CYC cycles of the on phase. A trip during the first BLANK_CYC cycles is ignored.
- R4: The state after a trip is fast decay for floor(5*TOFF_CYC/16) cycles, which drives the diagonal opposite to the on phase.
- R5: Slow decay (gate_al_o and gate_bl_o on) fills the rest of the TOFF_CYC-cycle off-time, after which a new on phase starts.
- R6: A high izero_i during decay turns all recirculation gates off until the next on phase, and sets status bit 5.
- R7: While en_n_i is high the gates are off, but the regulator state (status bits 3:2; 0 idle, 1 on, 2 fast, 3 slow) keeps advancing.
- R8: While ot_flt_i or uv_flt_i is high the gates are off and status bit 1 is set. The gates resume once both flags clear.
- R9: The high and low gates of one leg are never on together. A change from one non-idle pattern to a different one passes through DEAD_CYC all-off cycles.
- R10: Polarity is latched at each on-phase start (status bit 4). A change of phase_i during the off-time applies from the next on phase.
- R11: A low sleep_n_i turns the gates off, returns the regulator to idle, clears ready and restarts the wake delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trip_i | input | 1 | Current-trip comparator |
| izero_i | input | 1 | Load current near zero |
| phase_i | input | 1 | Winding polarity request |
| en_n_i | input | 1 | Active-low output enable |
| sleep_n_i | input | 1 | Active-low sleep |
| ot_flt_i | input | 1 | Overtemperature flag |
| uv_flt_i | input | 1 | Undervoltage flag |
| gate_ah_o | output | 1 | Leg A high-side gate |
| gate_al_o | output | 1 | Leg A low-side gate |
| gate_bh_o | output | 1 | Leg B high-side gate |
| gate_bl_o | output | 1 | Leg B low-side gate |
| status_o | output | 6 | {cut, polarity, state[1:0], fault, ready} |

## Verification
Two situations are hard to reach from the ports. The first is a trip that lands inside the blanking window. The bench polls the state field until an on phase begins and pulses trip in that same cycle. The second is a polarity change inside an off-time. The bench waits for fast decay, pulses near-zero current, then flips the polarity before the next on phase. The dead interval after it is checked against the new diagonal.

// File: rtl/hbd_pkg.sv
package hbd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ON   = 2'd1,
    ST_FAST = 2'd2,
    ST_SLOW = 2'd3
  } reg_st_e;

  localparam int GATE_W = 4;

  // fast-decay share of the off-time: 5/16, rounded down
  function automatic int fast_cycles(int toff);
    return (toff * 5) / 16;
  endfunction

  // gate vector order {a_hi, a_lo, b_hi, b_lo}
  function automatic logic [GATE_W-1:0] bridge_pattern(reg_st_e st, logic ph, logic cut);
    logic [GATE_W-1:0] p;
    case (st)
      ST_ON:   p = ph ? 4'b1001 : 4'b0110;
      ST_FAST: p = cut ? 4'b0000 : (ph ? 4'b0110 : 4'b1001);
      ST_SLOW: p = cut ? 4'b0000 : 4'b0101;
      default: p = 4'b0000;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/hbd_wake.sv
module hbd_wake #(
  parameter int WAKE_CYC = 200000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_n_i,
  output logic ready_o
);
  localparam int WW = $clog2(WAKE_CYC + 1);
  localparam logic [WW-1:0] WAKE_END = WW'(WAKE_CYC);

  logic [WW-1:0] wcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               wcnt <= '0;
    else if (!sleep_n_i)      wcnt <= '0;
    else if (wcnt != WAKE_END) wcnt <= wcnt + 1'b1;
  end

  assign ready_o = (wcnt == WAKE_END);

  a_r11_sleep_drops_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_n_i |=> !ready_o);
  a_r1_ready_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_o && sleep_n_i) |=> ready_o);
endmodule

// File: rtl/hbd_regulator.sv
module hbd_regulator
  import hbd_pkg::*;
#(
  parameter int TOFF_CYC  = 48,
  parameter int BLANK_CYC = 6
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    run_i,
  input  logic    trip_i,
  input  logic    izero_i,
  input  logic    phase_i,
  output reg_st_e st_o,
  output logic    ph_o,
  output logic    cut_o
);
  localparam int FAST_LEN = fast_cycles(TOFF_CYC);
  localparam int OW = $clog2(TOFF_CYC);
  localparam int BW = $clog2(BLANK_CYC + 1);
  localparam logic [OW-1:0] FAST_END  = OW'(FAST_LEN - 1);
  localparam logic [OW-1:0] OFF_END   = OW'(TOFF_CYC - 1);
  localparam logic [BW-1:0] BLANK_END = BW'(BLANK_CYC);

  reg_st_e       st;
  logic          ph_q, cut_q;
  logic [OW-1:0] ocnt;
  logic [BW-1:0] bcnt;

  // named internal events
  logic trip_seen, fast_done, off_done, decaying;
  assign trip_seen = (st == ST_ON) && trip_i && (bcnt == BLANK_END);
  assign fast_done = (st == ST_FAST) && (ocnt == FAST_END);
  assign off_done  = (st == ST_SLOW) && (ocnt == OFF_END);
  assign decaying  = (st == ST_FAST) || (st == ST_SLOW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      ph_q  <= 1'b0;
      cut_q <= 1'b0;
      ocnt  <= '0;
      bcnt  <= '0;
    end else if (!run_i) begin
      st <= ST_IDLE;
    end else begin
      case (st)
        ST_IDLE: begin
          st    <= ST_ON;
          ph_q  <= phase_i;
          bcnt  <= '0;
          cut_q <= 1'b0;
        end
        ST_ON: begin
          if (trip_seen) begin
            st   <= ST_FAST;
            ocnt <= '0;
          end else if (bcnt != BLANK_END) begin
            bcnt <= bcnt + 1'b1;
          end
        end
        ST_FAST: begin
          ocnt <= ocnt + 1'b1;
          if (izero_i)   cut_q <= 1'b1;
          if (fast_done) st <= ST_SLOW;
        end
        ST_SLOW: begin
          if (izero_i) cut_q <= 1'b1;
          if (off_done) begin
            st    <= ST_ON;
            ph_q  <= phase_i;
            bcnt  <= '0;
            cut_q <= 1'b0;
          end else begin
            ocnt <= ocnt + 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign st_o  = st;
  assign ph_o  = ph_q;
  assign cut_o = cut_q;

  a_r3_blank_ignores_trip: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ON && bcnt != BLANK_END && run_i) |=> (st == ST_ON));
  a_r4_fast_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_FAST && ocnt != FAST_END && run_i) |=> (st == ST_FAST));
  a_r5_slow_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SLOW && !off_done && run_i) |=> (st == ST_SLOW));
  a_r10_phase_latched: assert property (@(posedge clk) disable iff (!rst_n)
    (decaying && !off_done) |=> $stable(ph_q));
endmodule

// File: rtl/hbd_deadtime.sv
module hbd_deadtime
  import hbd_pkg::*;
#(
  parameter int DEAD_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [GATE_W-1:0] want_i,
  output logic [GATE_W-1:0] gate_o
);
  localparam int DW = $clog2(DEAD_CYC + 1);
  localparam logic [DW-1:0] DEAD_END = DW'(DEAD_CYC);

  logic [GATE_W-1:0] gate_q;
  logic [DW-1:0]     dcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= '0;
      dcnt   <= '0;
    end else if (gate_q != '0) begin
      if (want_i != gate_q) begin
        gate_q <= '0;
        dcnt   <= DW'(1);
      end
    end else if (want_i != '0 && dcnt == DEAD_END) begin
      gate_q <= want_i;
      dcnt   <= '0;
    end else if (dcnt != DEAD_END) begin
      dcnt <= dcnt + 1'b1;
    end
  end

  assign gate_o = gate_q;

  a_r9_leg_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_q[3] && gate_q[2]) && !(gate_q[1] && gate_q[0]));
  a_r9_no_direct_swap: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_q != '0) |=> (gate_q == $past(gate_q) || gate_q == '0));
endmodule

// File: rtl/hbridge_decay_ctrl.sv
module hbridge_decay_ctrl
  import hbd_pkg::*;
#(
  parameter int TOFF_CYC  = 48,
  parameter int BLANK_CYC = 6,
  parameter int DEAD_CYC  = 2,
  parameter int WAKE_CYC  = 200000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       trip_i,
  input  logic       izero_i,
  input  logic       phase_i,
  input  logic       en_n_i,
  input  logic       sleep_n_i,
  input  logic       ot_flt_i,
  input  logic       uv_flt_i,
  output logic       gate_ah_o,
  output logic       gate_al_o,
  output logic       gate_bh_o,
  output logic       gate_bl_o,
  output logic [5:0] status_o
);
  logic              ready, run, fault, gate_block;
  reg_st_e           st;
  logic              ph, cut;
  logic [GATE_W-1:0] want, gates;

  hbd_wake #(.WAKE_CYC(WAKE_CYC)) u_wake (
    .clk(clk), .rst_n(rst_n), .sleep_n_i(sleep_n_i), .ready_o(ready)
  );

  assign run = sleep_n_i && ready;

  hbd_regulator #(.TOFF_CYC(TOFF_CYC), .BLANK_CYC(BLANK_CYC)) u_reg (
    .clk(clk), .rst_n(rst_n), .run_i(run), .trip_i(trip_i),
    .izero_i(izero_i), .phase_i(phase_i),
    .st_o(st), .ph_o(ph), .cut_o(cut)
  );

  assign fault      = ot_flt_i || uv_flt_i;
  assign gate_block = en_n_i || fault || !run;
  assign want       = gate_block ? '0 : bridge_pattern(st, ph, cut);

  hbd_deadtime #(.DEAD_CYC(DEAD_CYC)) u_dead (
    .clk(clk), .rst_n(rst_n), .want_i(want), .gate_o(gates)
  );

  assign {gate_ah_o, gate_al_o, gate_bh_o, gate_bl_o} = gates;
  assign status_o = {cut, ph, st, fault, ready};

  a_r7_enable_forces_off: assert property (@(posedge clk) disable iff (!rst_n)
    en_n_i |=> (gates == '0));
  a_r8_fault_forces_off: assert property (@(posedge clk) disable iff (!rst_n)
    (ot_flt_i || uv_flt_i) |=> (gates == '0));
  a_r11_sleep_forces_off: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_n_i |=> (gates == '0));
endmodule

// File: tb/sim_hbridge_decay_ctrl.sv
`timescale 1ns/1ps
module sim_hbridge_decay_ctrl;
  localparam int TOFF  = 48;
  localparam int BLANK = 6;
  localparam int DEAD  = 2;
  localparam int WAKE  = 40;
  localparam int FL    = (TOFF * 5) / 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trip = 0, izero = 0, phase = 1, en_n = 0, sleep_n = 1, ot = 0, uv = 0;
  logic gah, gal, gbh, gbl;
  logic [5:0] status;

  hbridge_decay_ctrl #(.TOFF_CYC(TOFF), .BLANK_CYC(BLANK), .DEAD_CYC(DEAD), .WAKE_CYC(WAKE)) u0 (
    .clk(clk), .rst_n(rst_n), .trip_i(trip), .izero_i(izero), .phase_i(phase),
    .en_n_i(en_n), .sleep_n_i(sleep_n), .ot_flt_i(ot), .uv_flt_i(uv),
    .gate_ah_o(gah), .gate_al_o(gal), .gate_bh_o(gbh), .gate_bl_o(gbl),
    .status_o(status)
  );

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  string cur_req = "R1";
  bit mon_on = 0;

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] fets(int st, bit ph, bit cut);
    bit ah = 0, al = 0, bh = 0, bl = 0;
    if (st == 1) begin ah = ph; bl = ph; bh = !ph; al = !ph; end
    else if (st == 2 && !cut) begin ah = !ph; bl = !ph; bh = ph; al = ph; end
    else if (st == 3 && !cut) begin al = 1; bl = 1; end
    return {ah, al, bh, bl};
  endfunction

  // behavioural reference model
  int m_wk, m_st, m_bc, m_oc, m_dc;
  bit m_ph, m_cut;
  logic [3:0] m_g;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_wk = 0; m_st = 0; m_bc = 0; m_oc = 0; m_dc = 0; m_ph = 0; m_cut = 0; m_g = 0;
    end else begin
      bit rdy, blk;
      logic [3:0] want;
      rdy  = (m_wk == WAKE);
      blk  = en_n || ot || uv || !sleep_n || !rdy;
      want = blk ? 4'b0 : fets(m_st, m_ph, m_cut);
      if (m_g != 0) begin
        if (want != m_g) begin m_g = 0; m_dc = 1; end
      end else if (want != 0 && m_dc >= DEAD) begin
        m_g = want; m_dc = 0;
      end else if (m_dc < DEAD) m_dc++;
      if (!sleep_n || !rdy) m_st = 0;
      else case (m_st)
        0: begin m_st = 1; m_ph = phase; m_bc = 0; m_cut = 0; end
        1: if (trip && m_bc == BLANK) begin m_st = 2; m_oc = 0; end
           else if (m_bc < BLANK) m_bc++;
        2: begin if (izero) m_cut = 1; if (m_oc == FL - 1) m_st = 3; m_oc++; end
        default: begin
          if (izero) m_cut = 1;
          if (m_oc == TOFF - 1) begin m_st = 1; m_ph = phase; m_bc = 0; m_cut = 0; end
          else m_oc++;
        end
      endcase
      if (!sleep_n) m_wk = 0; else if (m_wk < WAKE) m_wk++;
    end
  end

  // per-cycle comparison and run-length monitor
  int fast_run = 0, slow_run = 0, last_fast = 0, last_slow = 0;
  logic [3:0] prev_g = 0;
  always @(negedge clk) begin
    #1;
    if (mon_on) begin
      logic [3:0] g;
      logic [5:0] exp_s;
      g = {gah, gal, gbh, gbl};
      exp_s = {m_cut, m_ph, 2'(m_st), ot | uv, 1'(m_wk == WAKE)};
      check(g == m_g, cur_req, g, m_g);
      check(status == exp_s, cur_req, status, exp_s);
      check(!(g[3] && g[2]) && !(g[1] && g[0]), "R9 leg", g, 0);
      check(!(prev_g != 0 && g != 0 && g != prev_g), "R9 gap", g, prev_g);
      prev_g = g;
      if (g == 4'b0110) fast_run++; else if (fast_run > 0) begin last_fast = fast_run; fast_run = 0; end
      if (g == 4'b0101) slow_run++; else if (slow_run > 0) begin last_slow = slow_run; slow_run = 0; end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 60000) begin
      fails++;
      $display("FAIL watchdog act=%0d exp=done", cyc);
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_st(int s, string req);
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (status[3:2] == 2'(s)) return;
    end
    check(0, req, status[3:2], s);
  endtask

  initial begin
    tick(4);
    check({gah, gal, gbh, gbl} == 0, "R1 reset gates", {gah, gal, gbh, gbl}, 0);
    check(status == 0, "R1 reset status", status, 0);
    rst_n = 1;
    mon_on = 1;
    cur_req = "R1";
    tick(WAKE + 2);
    check(status[0] == 1, "R1 ready", status[0], 1);

    cur_req = "R2";
    tick(20);
    check({gah, gal, gbh, gbl} == 4'b1001, "R2 on ph1", {gah, gal, gbh, gbl}, 4'b1001);

    cur_req = "R4 R5";
    trip = 1;
    tick(3 * TOFF);
    trip = 0;
    check(last_fast == FL - DEAD, "R4 fast run", last_fast, FL - DEAD);
    check(last_slow == TOFF - FL - DEAD, "R5 slow run", last_slow, TOFF - FL - DEAD);

    cur_req = "R3";
    wait_st(1, "R3 on");
    trip = 1;
    tick(1);
    trip = 0;
    tick(3);
    check(status[3:2] == 2'd1, "R3 blank ignore", status[3:2], 1);
    tick(10);
    trip = 1;
    tick(1);
    trip = 0;
    tick(1);
    check(status[3:2] == 2'd2, "R3 trip taken", status[3:2], 2);

    cur_req = "R6";
    tick(DEAD + 2);
    izero = 1;
    tick(1);
    izero = 0;
    phase = 0;
    tick(DEAD + 3);
    check({gah, gal, gbh, gbl} == 0, "R6 cut gates", {gah, gal, gbh, gbl}, 0);
    check(status[5] == 1, "R6 cut flag", status[5], 1);

    cur_req = "R10";
    wait_st(1, "R10 on");
    tick(DEAD + 2);
    check({gah, gal, gbh, gbl} == 4'b0110, "R10 new phase", {gah, gal, gbh, gbl}, 4'b0110);
    check(status[5] == 0, "R6 cut released", status[5], 0);
    phase = 1;

    cur_req = "R7";
    en_n = 1;
    trip = 1;
    begin
      bit saw_f = 0, saw_s = 0;
      for (int i = 0; i < 2 * TOFF; i++) begin
        tick(1);
        if (status[3:2] == 2'd2) saw_f = 1;
        if (status[3:2] == 2'd3) saw_s = 1;
      end
      check({gah, gal, gbh, gbl} == 0, "R7 gates off", {gah, gal, gbh, gbl}, 0);
      check(saw_f && saw_s, "R7 state advances", {saw_f, saw_s}, 3);
    end
    en_n = 0;
    trip = 0;
    tick(TOFF + 10);

    cur_req = "R8";
    ot = 1;
    tick(20);
    check({gah, gal, gbh, gbl} == 0, "R8 ot off", {gah, gal, gbh, gbl}, 0);
    check(status[1] == 1, "R8 fault bit", status[1], 1);
    ot = 0;
    uv = 1;
    tick(20);
    check({gah, gal, gbh, gbl} == 0, "R8 uv off", {gah, gal, gbh, gbl}, 0);
    uv = 0;
    tick(20);
    check({gah, gal, gbh, gbl} != 0, "R8 recovery", {gah, gal, gbh, gbl}, 1);

    cur_req = "R11";
    sleep_n = 0;
    tick(5);
    check(status[0] == 0 && status[3:2] == 0, "R11 idle", status, 0);
    check({gah, gal, gbh, gbl} == 0, "R11 gates off", {gah, gal, gbh, gbl}, 0);
    sleep_n = 1;
    tick(WAKE - 1);
    check(status[0] == 0, "R11 wake pending", status[0], 0);
    tick(1);
    check(status[0] == 1, "R11 wake done", status[0], 1);
    tick(30);

    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule